// File: doc/BRIEF.md
# GPIO Bank with Change Interrupts

This block is an eight-pin general-purpose I/O bank driven by a simple register interface. A bus front end presents single-cycle write and read strobes with a 3-bit register address. Each pin can be configured as an input or an output. An output pin can drive both levels or act as open-drain. The bank feeds tri-state pad controls: one output value and one output enable per pin.

Every level change on an input pin is synchronised and then latched into a sticky status register. This happens whether or not interrupts are enabled. A change raises the open-drain alert line only when three things hold: the global enable is on, the pin's mask bit is on, and the pin is an input. The alert is released when the host reads the status register or pulses the alert-acknowledge input.

A fan mode hands the upper four pins to a 4-bit fan-speed register. Those pins are then always driven, and their direction, drive-type and mask bits are ignored. They also produce no status or alert events.

Register map (3-bit address):
- 0: control. Bit 0 is the global interrupt enable. Bit 1 is fan mode.
- 1: direction.
- 2: drive type.
- 3: interrupt mask.
- 4: output value.
- 5: status.
- 6: synchronised pin levels, read only.
- 7: fan speed, bits 3:0.

Top module: `gpio_bank`

## Requirements
- R1: Direction register (address 1), bit i: 1 makes pin i an output and 0 makes it an input. An input pin has pad_oe[i]=0.
- R2: Drive-type register (address 2), bit i selects the drive of output pin i, using the output-value register (address 4).
  - 0 selects push-pull: pad_oe[i]=1 and pad_out[i] equals the value bit.
  - 1 selects open-drain: pad_out[i]=0 and pad_oe[i] is the inverse of the value bit.
- R3: A rising or falling change on an input pin sets that pin's bit in the status register (address 5), whatever the enables are. Changes on output pins set nothing. A change is visible in status three clock edges after pad_in changes.
- R4: A status read returns the status and clears every bit. A change that is latched on the same edge as the read survives the clear.
- R5: alert_oe (1 = pull the active-low alert line low) goes to 1 only after a change on a pin for which all three hold: control bit 0 is 1, the mask bit (address 3) is 1, and the pin is an input.
- R6: A status read or an alert_ack pulse releases alert_oe on the next edge. It stays released until a new qualifying change occurs.
- R7: With control bit 1 set, pin 4+k is driven push-pull from fan-speed bit k (k = 0..3). The direction, drive-type and output-value bits of pins 7:4 are ignored.
- R8: In fan mode, pins 7:4 set no status bits and raise no alert. Pins 3:0 keep working normally.
- R9: After reset, every register is zero, all pads are released, alert_oe is 0 and rdata is 0.
- R10: A read returns its data on the edge that samples rd_en. Configuration registers read back what was written. Address 6 returns the synchronised pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| alert_ack | input | 1 | Alert-response acknowledge, releases the alert |
| alert_oe | output | 1 | Pulls the open-drain active-low alert line low when 1 |

## Verification
The hardest case to reach is a status read on the very edge that latches a new pin change. The read must return the old contents while keeping the new bit. The stimulus gets there by counting edges from the negedge where pad_in toggles: the read strobe is raised two negedges later, so it meets the change on the third edge. A second read then shows the surviving bit. Fan mode is covered by toggling upper pins with every enable on and watching that both status and alert stay quiet, while a lower pin still alerts.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W   = 3;
  localparam int CTRL_GIE = 0;
  localparam int CTRL_FAN = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_DIR   = 3'd1,
    RA_DRIVE = 3'd2,
    RA_MASK  = 3'd3,
    RA_OUT   = 3'd4,
    RA_STAT  = 3'd5,
    RA_PINS  = 3'd6,
    RA_FAN   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] change
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pad_in[i]};
        prev  <= chain[STAGES-1];
      end
    end
    assign level[i]  = chain[STAGES-1];
    assign change[i] = chain[STAGES-1] ^ prev;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int FAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  status,
  input  logic [NPINS-1:0]  level,
  output logic              gie,
  output logic              fan_en,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  drive_od,
  output logic [NPINS-1:0]  imask,
  output logic [NPINS-1:0]  outv,
  output logic [FAN_W-1:0]  fanval,
  output logic [NPINS-1:0]  rdata,
  output logic              stat_rd
);
  reg_addr_e         ra;
  logic [NPINS-1:0]  rd_mux;

  assign ra      = reg_addr_e'(addr);
  assign stat_rd = rd_en && (ra == RA_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie      <= 1'b0;
      fan_en   <= 1'b0;
      dir      <= '0;
      drive_od <= '0;
      imask    <= '0;
      outv     <= '0;
      fanval   <= '0;
    end else if (wr_en) begin
      case (ra)
        RA_CTRL: begin
          gie    <= wdata[CTRL_GIE];
          fan_en <= wdata[CTRL_FAN];
        end
        RA_DIR:   dir      <= wdata;
        RA_DRIVE: drive_od <= wdata;
        RA_MASK:  imask    <= wdata;
        RA_OUT:   outv     <= wdata;
        RA_FAN:   fanval   <= wdata[FAN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (ra)
      RA_CTRL: begin
        rd_mux[CTRL_GIE] = gie;
        rd_mux[CTRL_FAN] = fan_en;
      end
      RA_DIR:   rd_mux = dir;
      RA_DRIVE: rd_mux = drive_od;
      RA_MASK:  rd_mux = imask;
      RA_OUT:   rd_mux = outv;
      RA_STAT:  rd_mux = status;
      RA_PINS:  rd_mux = level;
      RA_FAN:   rd_mux = {{(NPINS-FAN_W){1'b0}}, fanval};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10: a write to the direction register is visible on the next cycle
  a_r10_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ra == RA_DIR) |=> (dir == $past(wdata)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int NPINS = 8,
  parameter int FAN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] drive_od,
  input  logic [NPINS-1:0] outv,
  input  logic             fan_en,
  input  logic [FAN_W-1:0] fanval,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  localparam int FAN_LO = NPINS - FAN_W;

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic gp_out, gp_oe;
    always_comb begin
      if (!dir[i]) begin
        gp_out = 1'b0;
        gp_oe  = 1'b0;
      end else if (drive_od[i]) begin
        gp_out = 1'b0;
        gp_oe  = ~outv[i];
      end else begin
        gp_out = outv[i];
        gp_oe  = 1'b1;
      end
    end

    logic nxt_out, nxt_oe;
    if (i >= FAN_LO) begin : g_fan
      assign nxt_out = fan_en ? fanval[i-FAN_LO] : gp_out;
      assign nxt_oe  = fan_en ? 1'b1 : gp_oe;

      // R7: fan mode drives the pin from its fan-speed bit
      a_r7_fan_drive: assert property (@(posedge clk) disable iff (rst)
        $past(fan_en) |-> (pad_oe[i] && pad_out[i] == $past(fanval[i-FAN_LO])));
    end else begin : g_gp
      assign nxt_out = gp_out;
      assign nxt_oe  = gp_oe;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        pad_out[i] <= nxt_out;
        pad_oe[i]  <= nxt_oe;
      end
    end

    // R1: an input pin never enables its pad driver (outside fan takeover)
    a_r1_input_released: assert property (@(posedge clk) disable iff (rst)
      ($past(!dir[i]) && !(i >= FAN_LO && $past(fan_en))) |-> !pad_oe[i]);

    // R2: open-drain only ever pulls low
    a_r2_open_drain: assert property (@(posedge clk) disable iff (rst)
      ($past(dir[i] && drive_od[i]) && !(i >= FAN_LO && $past(fan_en)))
        |-> (!pad_out[i] && pad_oe[i] == !$past(outv[i])));
  end
endmodule

// File: rtl/gpio_alert.sv
module gpio_alert #(
  parameter int NPINS = 8,
  parameter int FAN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] change,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] imask,
  input  logic             gie,
  input  logic             fan_en,
  input  logic             stat_rd,
  input  logic             alert_ack,
  output logic [NPINS-1:0] status,
  output logic             alert_oe
);
  localparam int FAN_LO = NPINS - FAN_W;
  localparam logic [NPINS-1:0] FAN_PINS = {{FAN_W{1'b1}}, {FAN_LO{1'b0}}};

  logic [NPINS-1:0] is_input, ev_set, ev_qual;

  assign is_input = ~dir & ~(FAN_PINS & {NPINS{fan_en}});
  assign ev_set   = change & is_input;
  assign ev_qual  = ev_set & imask & {NPINS{gie}};

  always_ff @(posedge clk) begin
    if (rst)          status <= '0;
    else if (stat_rd) status <= ev_set;
    else              status <= status | ev_set;
  end

  always_ff @(posedge clk) begin
    if (rst)                       alert_oe <= 1'b0;
    else if (|ev_qual)             alert_oe <= 1'b1;
    else if (stat_rd || alert_ack) alert_oe <= 1'b0;
  end

  // R3: a detected input change is held in status after the edge
  a_r3_change_latched: assert property (@(posedge clk) disable iff (rst)
    (|(change & ~dir & ~FAN_PINS)) |=> ((status & $past(change & ~dir & ~FAN_PINS))
                                        == $past(change & ~dir & ~FAN_PINS)));

  // R5: the alert only rises after an enabled change from an input pin
  a_r5_alert_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_oe) |-> $past(gie && |(change & imask & ~dir)));

  // R6: read or acknowledge releases the alert unless a new event arrives
  a_r6_alert_release: assert property (@(posedge clk) disable iff (rst)
    ((stat_rd || alert_ack) && !(|ev_qual)) |=> !alert_oe);

  // R8: fan pins never set status while fan mode is on
  a_r8_fan_quiet: assert property (@(posedge clk) disable iff (rst)
    (fan_en && stat_rd) |=> ((status & FAN_PINS) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic              alert_ack,
  output logic              alert_oe
);
  localparam int FAN_W = NPINS / 2;

  logic [NPINS-1:0] level, change, status;
  logic [NPINS-1:0] dir, drive_od, imask, outv;
  logic [FAN_W-1:0] fanval;
  logic             gie, fan_en, stat_rd;

  gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .level(level), .change(change)
  );

  gpio_regs #(.NPINS(NPINS), .FAN_W(FAN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status), .level(level), .gie(gie),
    .fan_en(fan_en), .dir(dir), .drive_od(drive_od), .imask(imask),
    .outv(outv), .fanval(fanval), .rdata(rdata), .stat_rd(stat_rd)
  );

  gpio_pad_ctl #(.NPINS(NPINS), .FAN_W(FAN_W)) u_pad (
    .clk(clk), .rst(rst), .dir(dir), .drive_od(drive_od), .outv(outv),
    .fan_en(fan_en), .fanval(fanval), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_alert #(.NPINS(NPINS), .FAN_W(FAN_W)) u_alert (
    .clk(clk), .rst(rst), .change(change), .dir(dir), .imask(imask),
    .gie(gie), .fan_en(fan_en), .stat_rd(stat_rd), .alert_ack(alert_ack),
    .status(status), .alert_oe(alert_oe)
  );

  // R9: reset releases every pad and the alert
  a_r9_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && !alert_oe && rdata == '0));
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, alert_ack = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe;
  logic       alert_oe;
  int         checks = 0, errors = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alert_ack(alert_ack), .alert_oe(alert_oe)
  );

  // fields: ctrl, dir, drive, outv, fan, expected oe, expected out
  localparam logic [55:0] VECS [6] = '{
    {8'h00, 8'hFF, 8'h00, 8'hA5, 8'h00, 8'hFF, 8'hA5},
    {8'h00, 8'hFF, 8'hFF, 8'hA5, 8'h00, 8'h5A, 8'h00},
    {8'h00, 8'h0F, 8'h03, 8'h0E, 8'h00, 8'h0D, 8'h0C},
    {8'h02, 8'h00, 8'h00, 8'h00, 8'h0A, 8'hF0, 8'hA0},
    {8'h02, 8'hFF, 8'hFF, 8'h3C, 8'h05, 8'hF3, 8'h50},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 pad_oe", pad_oe, 8'h00);
    check("R9 alert", {7'b0, alert_oe}, 8'h00);
    check("R9 rdata", rdata, 8'h00);
    rdreg(3'd1, rd); check("R9 dir", rd, 8'h00);

    // R1 R2 R7: pad drive table
    for (int k = 0; k < 6; k++) begin
      logic [55:0] v;
      v = VECS[k];
      wr(3'd0, v[55:48]); wr(3'd1, v[47:40]); wr(3'd2, v[39:32]);
      wr(3'd4, v[31:24]); wr(3'd7, v[23:16]);
      repeat (2) @(negedge clk);
      check(v[55:48][1] ? "R7 oe" : "R1 oe", pad_oe, v[15:8]);
      check(v[55:48][1] ? "R7 out" : "R2 out", pad_out, v[7:0]);
    end

    rdreg(3'd5, rd);
    // R3: rising, enables off
    pad_in = 8'h04; settle();
    check("R5 alert off", {7'b0, alert_oe}, 8'h00);
    rdreg(3'd5, rd); check("R3 rise", rd, 8'h04);
    rdreg(3'd5, rd); check("R4 cleared", rd, 8'h00);
    pad_in = 8'h00; settle();
    rdreg(3'd5, rd); check("R3 fall", rd, 8'h04);

    // R5 / R6
    wr(3'd0, 8'h01); wr(3'd3, 8'h04);
    pad_in = 8'h04; settle();
    check("R5 alert on", {7'b0, alert_oe}, 8'h01);
    @(negedge clk); alert_ack = 1'b1;
    @(negedge clk); alert_ack = 1'b0;
    check("R6 ack", {7'b0, alert_oe}, 8'h00);
    rdreg(3'd5, rd); check("R3 kept after ack", rd, 8'h04);
    pad_in = 8'h0C; settle();
    check("R5 unmasked pin", {7'b0, alert_oe}, 8'h00);
    rdreg(3'd5, rd); check("R3 unmasked", rd, 8'h08);
    pad_in = 8'h08; settle();
    check("R5 alert fall", {7'b0, alert_oe}, 8'h01);
    rdreg(3'd5, rd); check("R6 read releases", {7'b0, alert_oe}, 8'h00);
    wr(3'd1, 8'h04);
    pad_in = 8'h0C; settle();
    check("R5 output pin", {7'b0, alert_oe}, 8'h00);
    rdreg(3'd5, rd); check("R3 output pin", rd, 8'h00);
    wr(3'd1, 8'h00);

    // R8: fan mode
    wr(3'd0, 8'h03); wr(3'd3, 8'hFF);
    pad_in = 8'h4C; settle();
    check("R8 fan alert", {7'b0, alert_oe}, 8'h00);
    rdreg(3'd5, rd); check("R8 fan status", rd, 8'h00);
    pad_in = 8'h4E; settle();
    check("R8 low pin alert", {7'b0, alert_oe}, 8'h01);
    rdreg(3'd5, rd); check("R8 low pin status", rd, 8'h02);

    // R4: read on the edge that latches a change
    wr(3'd0, 8'h00);
    @(negedge clk); pad_in = 8'h4F;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 3'd5;
    @(negedge clk); rd_en = 1'b0;
    check("R4 same-edge old", rdata, 8'h00);
    rdreg(3'd5, rd); check("R4 same-edge kept", rd, 8'h01);

    // R10
    pad_in = 8'h5A; settle();
    rdreg(3'd6, rd); check("R10 pins", rd, 8'h5A);
    wr(3'd2, 8'h3C); rdreg(3'd2, rd); check("R10 readback", rd, 8'h3C);
    wr(3'd7, 8'h09); rdreg(3'd7, rd); check("R10 fan readback", rd, 8'h09);
    rdreg(3'd5, rd);

    // R9: mid-run reset
    wr(3'd1, 8'hFF); wr(3'd0, 8'h01);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 pads after reset", pad_oe, 8'h00);
    rdreg(3'd0, rd); check("R9 ctrl after reset", rd, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule